// File: doc/BRIEF.md
# Indexed-Coupling Selective Accumulator MAC

This block computes one row of an interaction sum, the sum over j of x_j times J_ij. It never turns the couplings back into values while the row streams in. Each coupling arrives as a small index code next to its position value x_j. The block adds x_j into the one accumulator that belongs to that code. Because every code stands for one of only a few distinct coupling values, this inner loop is adders only.

When the element flagged as last of row is taken, the block copies the accumulator bank into a snapshot. A sequencer then walks the snapshot through one shared multiplier. It weights each accumulator with its entry from a small writable value table and adds the products. The result is saturated to the output width and presented for one cycle with a valid strobe. The next row can stream in while the multiply phase runs, provided each row has at least NV+1 elements.

Position values are 16-bit Q1.14 and table values are 16-bit Q4.11. The result is therefore a raw fixed-point sum with 25 fractional bits.

Top module: `isacc_mac`

## Requirements
- R1: While reset is held and after it is released, `res_valid` is 0 and `res_data` is 0 until a row completes.
- R2: For a row of elements (x_j, code_j), `res_data` equals the sum of x_j * T[code_j] over all elements with code_j < NV. Here x_j is the signed 16-bit input, T[t] is the signed 16-bit table entry, and the result has no rescaling.
- R3: An element whose code is NV or higher adds nothing to the row result; it still counts as an element, and its last flag still ends the row.
- R4: Cycles with `in_valid` low have no effect, whatever `in_x`, `in_code` and `in_last` carry.
- R5: Every accumulator restarts from zero on the first valid element after a last-of-row element, so consecutive rows, including back-to-back rows, give independent results.
- R6: If the last element of a row is taken at clock edge k, `res_valid` is high for exactly one cycle, starting at edge k+NV+1.
- R7: A sum above 2^(OUT_W-1)-1 gives 2^(OUT_W-1)-1, and a sum below -2^(OUT_W-1) gives -2^(OUT_W-1).
- R8: A cycle with `tbl_we` high writes `tbl_data` into table entry `tbl_addr` when `tbl_addr` < NV; a write to an address of NV or more changes nothing. A row uses the table contents present during its multiply phase.
- R9: A row of up to NMAX elements with any x values, including all -32768, is summed without accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Element present this cycle |
| in_x | input | X_W (16) | Signed Q1.14 position value |
| in_code | input | IDX_W (2) | Coupling index code |
| in_last | input | 1 | Element is the last one of its row |
| tbl_we | input | 1 | Value table write enable |
| tbl_addr | input | IDX_W (2) | Value table entry to write |
| tbl_data | input | TBL_W (16) | Signed Q4.11 coupling value |
| res_valid | output | 1 | One-cycle strobe with the row result |
| res_data | output | OUT_W (32) | Saturated signed row result |

## Verification
A short hand-built row with mixed signs and all in-range codes shows that each code reaches its own accumulator and table entry. Rows made only of out-of-range codes, and rows mixing them in, separate a dropped element from one wrongly folded into an accumulator. Random rows with idle cycles carrying random payload check the sum against a bench model and show that idle cycles are ignored. Back-to-back minimum-length rows show the restart at a row boundary and the snapshot that overlaps streaming with the multiply phase. The remaining directed rows cover full-scale inputs that must saturate in both directions, a row of NMAX elements at the most negative x, a write to an address outside the table, and a table update between rows.

// File: rtl/isacc_pkg.sv
// Package: shared phase type and width helper for the indexed-coupling MAC.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package isacc_pkg;

    // Phase of the scale-and-reduce sequencer.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SCALE = 2'd1,
        PH_EMIT  = 2'd2
    } phase_t;

    // Bits needed to address n entries, never less than one.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/isacc_table.sv
// Module: isacc_table
// Holds the NV coupling values, one per index code.
// Assumes writes to addresses of NV or more must be dropped.
// Entries reset to zero.
module isacc_table #(
    parameter int NV    = 3,
    parameter int TBL_W = 16,
    parameter int IDX_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_addr,
    input  logic [TBL_W-1:0]            wr_data,
    output logic [NV-1:0][TBL_W-1:0]    tbl
);

    for (genvar t = 0; t < NV; t++) begin : g_entry
        logic hit;
        assign hit = wr_en && (int'(wr_addr) == t);

        // Entry t: loads on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[t] <= '0;
            end else if (hit) begin
                tbl[t] <= wr_data;
            end
        end

        AST_TBL_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_addr) >= NV) |=> $stable(tbl[t])); // R8
    end

endmodule

// File: rtl/isacc_bank.sv
// Module: isacc_bank
// One adder-only accumulator per coupling index code. A valid element adds its
// sign-extended x into the accumulator whose index equals its code; codes of
// NV or more match no accumulator. The first valid element after a
// last-of-row restarts every accumulator from zero. On the last element the
// updated bank is copied into a snapshot for the multiply phase.
// Assumes ACC_W is wide enough for the longest row (guard bits from NMAX).
module isacc_bank #(
    parameter int NV    = 3,
    parameter int X_W   = 16,
    parameter int ACC_W = 27,
    parameter int IDX_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        elem_valid,
    input  logic [X_W-1:0]              elem_x,
    input  logic [IDX_W-1:0]            elem_code,
    input  logic                        elem_last,
    output logic [NV-1:0][ACC_W-1:0]    snap
);

    logic                           fresh_q;
    logic signed [ACC_W-1:0]        x_ext;
    logic [NV-1:0][ACC_W-1:0]       acc_q;

    assign x_ext = ACC_W'($signed(elem_x));

    // Row-start flag: set by reset and by every last-of-row element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_q <= 1'b1;
        end else if (elem_valid) begin
            fresh_q <= elem_last;
        end
    end

    for (genvar t = 0; t < NV; t++) begin : g_acc
        logic                       sel;
        logic signed [ACC_W-1:0]    base;
        logic signed [ACC_W-1:0]    addend;
        logic signed [ACC_W-1:0]    acc_nxt;

        // Indicator select and restart for accumulator t.
        always_comb begin
            sel     = elem_valid && (int'(elem_code) == t);
            addend  = sel ? x_ext : '0;
            base    = (elem_valid && fresh_q) ? '0 : $signed(acc_q[t]);
            acc_nxt = base + addend;
        end

        // Accumulator t: advances only on valid elements.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q[t] <= '0;
            end else if (elem_valid) begin
                acc_q[t] <= acc_nxt;
            end
        end

        // Snapshot t: captures the finished row sum on the last element.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap[t] <= '0;
            end else if (elem_valid && elem_last) begin
                snap[t] <= acc_nxt;
            end
        end

        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !elem_valid |=> $stable(acc_q[t])); // R4

        AST_FOREIGN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            (elem_valid && !fresh_q && int'(elem_code) >= NV) |=> $stable(acc_q[t])); // R3

        AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
            (elem_valid && fresh_q && int'(elem_code) != t) |=> (acc_q[t] == '0)); // R5
    end

endmodule

// File: rtl/isacc_scale.sv
// Module: isacc_scale
// Multiplies each snapshot accumulator by its table value through one shared
// multiplier, one index per cycle, sums the products and saturates the total.
// Timing: start at edge k, products added at edges k+1..k+NV, result strobe
// from edge k+NV+1. Assumes no new start while products are still being added.
module isacc_scale #(
    parameter int NV    = 3,
    parameter int ACC_W = 27,
    parameter int TBL_W = 16,
    parameter int OUT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NV-1:0][ACC_W-1:0]    snap,
    input  logic [NV-1:0][TBL_W-1:0]    tbl,
    output logic                        res_valid,
    output logic [OUT_W-1:0]            res_data
);
    import isacc_pkg::*;

    localparam int CNT_W  = idx_bits(NV);
    localparam int PROD_W = ACC_W + TBL_W;
    localparam int SUM_W  = PROD_W + idx_bits(NV) + 1;

    phase_t                     phase_q;
    logic [CNT_W-1:0]           cnt_q;
    logic signed [SUM_W-1:0]    sum_q;
    logic signed [ACC_W-1:0]    op_acc;
    logic signed [TBL_W-1:0]    op_tbl;
    logic signed [PROD_W-1:0]   prod;
    logic signed [SUM_W-1:0]    hi_lim;
    logic signed [SUM_W-1:0]    lo_lim;
    logic [OUT_W-1:0]           sat_val;
    logic                       last_idx;

    // Operand select and the shared multiplier.
    always_comb begin
        op_acc   = $signed(snap[cnt_q]);
        op_tbl   = $signed(tbl[cnt_q]);
        prod     = PROD_W'(op_acc) * PROD_W'(op_tbl);
        last_idx = (int'(cnt_q) == NV - 1);
    end

    // Saturation of the finished sum to the output range.
    always_comb begin
        hi_lim = SUM_W'($signed({1'b0, {(OUT_W-1){1'b1}}}));
        lo_lim = SUM_W'($signed({1'b1, {(OUT_W-1){1'b0}}}));
        if (sum_q > hi_lim) begin
            sat_val = hi_lim[OUT_W-1:0];
        end else if (sum_q < lo_lim) begin
            sat_val = lo_lim[OUT_W-1:0];
        end else begin
            sat_val = sum_q[OUT_W-1:0];
        end
    end

    // Sequencer: clear on start, one product per cycle, then emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            sum_q   <= '0;
        end else begin
            case (phase_q)
                PH_SCALE: begin
                    sum_q <= sum_q + SUM_W'(prod);
                    if (last_idx) begin
                        phase_q <= PH_EMIT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (start) begin
                        phase_q <= PH_SCALE;
                        cnt_q   <= '0;
                        sum_q   <= '0;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
            endcase
        end
    end

    // Result register: strobe and value for one cycle after the emit phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= (phase_q == PH_EMIT);
            if (phase_q == PH_EMIT) begin
                res_data <= sat_val;
            end
        end
    end

    AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (phase_q != PH_SCALE)); // R6

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R6

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SCALE) |-> (int'(cnt_q) < NV)); // R2

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> (res_valid || $stable(res_data))); // R7

endmodule

// File: rtl/isacc_mac.sv
// Module: isacc_mac (top)
// Indexed-coupling selective accumulator MAC for one row of an interaction
// sum. Streams (x, code) elements into per-code accumulators, snapshots them
// on the last-of-row element, then weights each with its table value.
// Assumes rows of at least NV+1 elements and at most NMAX elements.
module isacc_mac #(
    parameter int NV    = 3,
    parameter int X_W   = 16,
    parameter int TBL_W = 16,
    parameter int NMAX  = 2048,
    parameter int OUT_W = 32,
    localparam int IDX_W = isacc_pkg::idx_bits(NV),
    localparam int ACC_W = X_W + $clog2(NMAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [X_W-1:0]      in_x,
    input  logic [IDX_W-1:0]    in_code,
    input  logic                in_last,
    input  logic                tbl_we,
    input  logic [IDX_W-1:0]    tbl_addr,
    input  logic [TBL_W-1:0]    tbl_data,
    output logic                res_valid,
    output logic [OUT_W-1:0]    res_data
);

    logic [NV-1:0][ACC_W-1:0]   snap;
    logic [NV-1:0][TBL_W-1:0]   tbl;
    logic                       row_done;

    assign row_done = in_valid && in_last;

    isacc_table #(
        .NV    (NV),
        .TBL_W (TBL_W),
        .IDX_W (IDX_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_addr (tbl_addr),
        .wr_data (tbl_data),
        .tbl     (tbl)
    );

    isacc_bank #(
        .NV    (NV),
        .X_W   (X_W),
        .ACC_W (ACC_W),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .elem_valid (in_valid),
        .elem_x     (in_x),
        .elem_code  (in_code),
        .elem_last  (in_last),
        .snap       (snap)
    );

    isacc_scale #(
        .NV    (NV),
        .ACC_W (ACC_W),
        .TBL_W (TBL_W),
        .OUT_W (OUT_W)
    ) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (row_done),
        .snap      (snap),
        .tbl       (tbl),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !res_valid); // R1

endmodule

// File: tb/isacc_mac_test.sv
// Bench for isacc_mac: directed corner rows plus seeded random rows, each
// result compared with a bench model of the row sum.
module isacc_mac_test;

    localparam int NV    = 3;
    localparam int IW    = 2;
    localparam int OUT_W = 32;
    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [15:0]        in_x = '0;
    logic [IW-1:0]      in_code = '0;
    logic               in_last = 1'b0;
    logic               tbl_we = 1'b0;
    logic [IW-1:0]      tbl_addr = '0;
    logic [15:0]        tbl_data = '0;
    logic               res_valid;
    logic [OUT_W-1:0]   res_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rows_sent = 0;
    int pulses = 0;
    bit done = 1'b0;

    logic signed [15:0] rx [0:2047];
    logic [IW-1:0]      rc [0:2047];
    int                 bt [0:NV-1];

    longint exp_q [$];
    int     cyc_q [$];
    string  tag_q [$];

    isacc_mac uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .in_code   (in_code),
        .in_last   (in_last),
        .tbl_we    (tbl_we),
        .tbl_addr  (tbl_addr),
        .tbl_data  (tbl_data),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint row_ref(input int n);
        longint s = 0;
        for (int j = 0; j < n; j++) begin
            if (int'(rc[j]) < NV) s += longint'(rx[j]) * longint'(bt[rc[j]]);
        end
        if (s > SMAX) s = SMAX;
        if (s < SMIN) s = SMIN;
        return s;
    endfunction

    task automatic check(input string req, input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Result monitor: value (R2 family) and strobe timing (R6).
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            pulses++;
            if (exp_q.size() == 0) begin
                check("R6 unexpected strobe", 1, 0);
            end else begin
                check(tag_q.pop_front(), longint'($signed(res_data)), exp_q.pop_front());
                check("R6 strobe cycle", cyc, cyc_q.pop_front());
            end
        end
    end

    task automatic wr_tbl(input int a, input int v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = IW'(a); tbl_data = 16'(v);
        @(negedge clk);
        tbl_we = 1'b0;
        if (a < NV) bt[a] = int'($signed(16'(v)));
    endtask

    // Streams rows rx/rc[0..n-1]; gap_pct inserts idle cycles with noise (R4).
    task automatic send_row(input int n, input int gap_pct, input string tag);
        for (int j = 0; j < n; j++) begin
            if (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
                @(negedge clk);
                in_valid = 1'b0; in_x = 16'($urandom);
                in_code = IW'($urandom); in_last = 1'($urandom);
            end
            @(negedge clk);
            in_valid = 1'b1; in_x = rx[j]; in_code = rc[j]; in_last = (j == n - 1);
            if (j == n - 1) begin
                exp_q.push_back(row_ref(n));
                cyc_q.push_back(cyc + NV + 2);
                tag_q.push_back(tag);
                rows_sent++;
            end
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic fill_rand(input int n);
        for (int j = 0; j < n; j++) begin
            rx[j] = 16'($urandom);
            rc[j] = IW'($urandom);
        end
    endtask

    initial begin
        void'($urandom(32'd77));
        for (int t = 0; t < NV; t++) bt[t] = 0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", res_valid, 0);
        check("R1 data in reset", res_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid after reset", res_valid, 0);
        check("R1 data after reset", res_data, 0);

        // R8: load table (Q4.11: 1.0, -0.5, 3.25)
        wr_tbl(0, 2048); wr_tbl(1, -1024); wr_tbl(2, 6656);

        // R2: directed mixed-sign row
        rx[0] = 16384; rx[1] = -16384; rx[2] = 8192; rx[3] = 100; rx[4] = -7;
        rc[0] = 0; rc[1] = 1; rc[2] = 2; rc[3] = 0; rc[4] = 2;
        send_row(5, 0, "R2 directed row"); idle(8);

        // R3: only out-of-range codes, then a mixed row
        for (int j = 0; j < 6; j++) begin rx[j] = 16'($urandom); rc[j] = 2'd3; end
        send_row(6, 0, "R3 all foreign codes"); idle(8);
        fill_rand(12); rc[3] = 2'd3; rc[7] = 2'd3; rc[11] = 2'd3;
        send_row(12, 0, "R3 mixed foreign codes"); idle(8);

        // R2/R4: random rows with noisy idle cycles
        for (int r = 0; r < 25; r++) begin
            int n = 4 + int'($urandom % 37);
            fill_rand(n);
            send_row(n, 30, "R2 R4 random row");
        end
        idle(8);

        // R5: back-to-back minimum-length rows
        for (int r = 0; r < 6; r++) begin
            fill_rand(NV + 1);
            send_row(NV + 1, 0, "R5 back-to-back row");
        end
        idle(8);

        // R8: write outside the table is ignored; in-range update takes effect
        wr_tbl(3, 12345);
        fill_rand(10); send_row(10, 0, "R8 foreign write ignored"); idle(8);
        wr_tbl(1, 300);
        send_row(10, 0, "R8 updated entry"); idle(8);

        // R7: saturation both ways
        wr_tbl(0, 32767);
        for (int j = 0; j < 40; j++) begin rx[j] = 16'sd32767; rc[j] = 0; end
        send_row(40, 0, "R7 positive saturation"); idle(8);
        wr_tbl(0, -32768);
        send_row(40, 0, "R7 negative saturation"); idle(8);

        // R9: full-length row at the most negative x
        wr_tbl(0, 1);
        for (int j = 0; j < 2048; j++) begin rx[j] = -16'sd32768; rc[j] = 0; end
        send_row(2048, 0, "R9 full-length row"); idle(8);
        check("R9 expected value", row_ref(2048), -64'sd67108864);

        idle(4);
        check("R6 one strobe per row", pulses, rows_sent);
        check("R6 no pending results", exp_q.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule